// File: doc/BRIEF.md
# Resistive touchscreen sampling sequencer

This block drives a four-wire resistive panel through a set of plate switch enables and a single ADC conversion slot. While nobody touches the panel it waits in an armed state, with the touch detector enabled and every plate switch open. A rising detector input starts a settle interval, after which the detector is read again. If the touch is still present, the sequencer disables the detector and measures three quantities in a fixed order: the X coordinate, the Y coordinate, and the pressure. Each quantity uses its own plate drive pattern and its own sense input.

Each measurement follows the same steps. The sequencer first takes one conversion and throws it away. It then waits a stabilisation interval. Finally it takes four conversions, and their sum divided by four becomes the result. Every conversion must complete within a timeout window. If any conversion is late, the whole coordinate set is abandoned and the pass starts again with a new detector check.

A fully measured set is reported when the next detector check still sees a touch. When the detector finds the panel released, the sequencer reports a release, which has pressure zero and the touch flag clear. Any set that was measured but not yet reported is dropped. The sequencer then returns to the armed state.

Top module: `ts_seq`

## Requirements
- R1: After reset, and whenever the block is armed, `det_en_o` and `irq_arm_o` are high, `sw_o` is zero, and `adc_req_o` and `rpt_valid_o` are low.
- R2: A high `touch_det_i` while armed starts a detector check. The check lasts DET_CYC cycles with `det_en_o` high and `sw_o` zero. The detector is then sampled. If it reads low, a release report appears in the cycle DET_CYC+1 after the cycle in which the touch was seen, and no conversion is requested.
- R3: X measurement closes the X+ high switch (`sw_o` bit 0) and the X- low switch (bit 1), giving `sw_o` = 5'b00011. The sense select is `adc_sel_o` = 0 (the Y+ plate), and the result appears on `rpt_x_o`.
- R4: Y measurement closes the Y+ high switch (bit 2) and the Y- low switch (bit 3), giving `sw_o` = 5'b01100. The sense select is `adc_sel_o` = 1 (the X- plate), and the result appears on `rpt_y_o`.
- R5: Pressure measurement closes the Y+ high switch (bit 2) and the X- high switch (bit 4), giving `sw_o` = 5'b10100, with X+ left floating. The sense select is `adc_sel_o` = 2 (the Y- plate), and the result appears on `rpt_p_o`.
- R6: The first conversion of each quantity is discarded. The next request follows exactly STAB_CYC+1 cycles after the cycle in which that discarded conversion's `adc_done_i` was accepted.
- R7: Each result is the floor of the sum of the four following 18-bit conversions divided by four. No bits are lost, even when the sum exceeds 18 bits.
- R8: Each pass requests five conversions per quantity, in the order X, Y, pressure. `det_en_o` is low on every request. `adc_req_o` is a single-cycle pulse.
- R9: If `adc_done_i` has not arrived within CONV_CYC cycles after a request, the pass is abandoned. `det_en_o` rises exactly CONV_CYC+1 cycles after the request cycle, and nothing from that pass is reported.
- R10: A complete set is reported as a one-cycle `rpt_valid_o` pulse with `rpt_touch_o` high. The pulse comes at the next detector check that still sees the touch. A pass that follows reporting runs again while the touch is held.
- R11: When a detector check reads no touch, the block reports `rpt_touch_o` low with `rpt_p_o` zero and `rpt_x_o`/`rpt_y_o` unchanged. It discards any unreported set and is armed (`irq_arm_o` high) in the same cycle as that report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| touch_det_i | input | 1 | Raw touch detector level |
| det_en_o | output | 1 | Touch detector enable (sensing configuration) |
| irq_arm_o | output | 1 | Armed, waiting for a touch to start a pass |
| sw_o | output | 5 | Plate switches: 0 X+ high, 1 X- low, 2 Y+ high, 3 Y- low, 4 X- high |
| adc_sel_o | output | 2 | Sense input: 0 Y+, 1 X-, 2 Y- |
| adc_req_o | output | 1 | One-cycle conversion request |
| adc_done_i | input | 1 | Conversion complete, data valid |
| adc_data_i | input | DATA_W | Conversion result |
| rpt_valid_o | output | 1 | Report strobe |
| rpt_touch_o | output | 1 | Touch flag of the report |
| rpt_x_o | output | DATA_W | Averaged X |
| rpt_y_o | output | DATA_W | Averaged Y |
| rpt_p_o | output | DATA_W | Averaged pressure, zero on release |

## Verification
Two cases are hard to reach from the ports. The first is a conversion that never completes in the middle of a pass while the touch is still held. The second is a release that arrives while a measured set is still waiting to be reported. The ADC responder in the bench can be told to withhold its answer to one chosen request within a pass. The bench then checks three things: the exact cycle in which the detector comes back, the number of requests made before the first report, and the values in that report. For the release case, the bench drops the touch as soon as the first report appears, so that the second pass completes and its set has to be thrown away.

// File: rtl/ts_seq_pkg.sv
package ts_seq_pkg;
  typedef enum logic [2:0] {ST_ARMED, ST_DET, ST_REQ, ST_WAIT, ST_STAB} st_e;
  typedef enum logic [1:0] {AX_X = 2'd0, AX_Y = 2'd1, AX_P = 2'd2} axis_e;

  localparam int SW_W = 5;
  // bit 0 X+ high, 1 X- low, 2 Y+ high, 3 Y- low, 4 X- high
  localparam logic [SW_W-1:0] SW_X = 5'b00011;
  localparam logic [SW_W-1:0] SW_Y = 5'b01100;
  localparam logic [SW_W-1:0] SW_P = 5'b10100;
endpackage

// File: rtl/ts_plate_map.sv
module ts_plate_map
  import ts_seq_pkg::*;
(
  input  axis_e           axis_i,
  input  logic            drive_i,
  output logic [SW_W-1:0] sw_o,
  output logic [1:0]      sel_o
);
  always_comb begin
    sw_o  = '0;
    sel_o = axis_i;
    if (drive_i) begin
      case (axis_i)
        AX_X:    sw_o = SW_X;
        AX_Y:    sw_o = SW_Y;
        default: sw_o = SW_P;
      endcase
    end
  end
endmodule

// File: rtl/ts_cnt.sv
module ts_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (ld_i)          cnt_q <= ld_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ts_avg.sv
module ts_avg #(
  parameter int DATA_W = 18,
  parameter int AVG_N  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] avg_o
);
  localparam int LG    = $clog2(AVG_N);
  localparam int SUM_W = DATA_W + LG;

  logic [SUM_W-1:0] sum_q, sum_n;

  assign sum_n = sum_q + SUM_W'(din_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (clr_i)  sum_q <= '0;
    else if (add_i)  sum_q <= sum_n;
  end

  // running sum including the current sample, divided by AVG_N (power of two)
  assign avg_o = sum_n[SUM_W-1 -: DATA_W];
endmodule

// File: rtl/ts_seq.sv
module ts_seq
  import ts_seq_pkg::*;
#(
  parameter int DATA_W   = 18,
  parameter int AVG_N    = 4,
  parameter int DET_CYC  = 500000,
  parameter int STAB_CYC = 200000,
  parameter int CONV_CYC = 500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              touch_det_i,
  output logic              det_en_o,
  output logic              irq_arm_o,
  output logic [4:0]        sw_o,
  output logic [1:0]        adc_sel_o,
  output logic              adc_req_o,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              rpt_valid_o,
  output logic              rpt_touch_o,
  output logic [DATA_W-1:0] rpt_x_o,
  output logic [DATA_W-1:0] rpt_y_o,
  output logic [DATA_W-1:0] rpt_p_o
);
  localparam int MAX_A   = (DET_CYC > STAB_CYC) ? DET_CYC : STAB_CYC;
  localparam int MAX_CYC = (MAX_A > CONV_CYC) ? MAX_A : CONV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int IDX_W   = $clog2(AVG_N + 1);

  st_e               st_q, st_n;
  axis_e             axis_q;
  logic [IDX_W-1:0]  smp_q;
  logic              set_ok_q;
  logic [DATA_W-1:0] x_q, y_q, p_q, avg;
  logic              ld, zero, acc_clr, acc_add, fin, rpt_set, rpt_rel, tmo;
  logic [CNT_W-1:0]  ld_val;

  ts_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld), .ld_val_i(ld_val), .zero_o(zero)
  );

  ts_avg #(.DATA_W(DATA_W), .AVG_N(AVG_N)) u_avg (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(acc_clr), .add_i(acc_add),
    .din_i(adc_data_i), .avg_o(avg)
  );

  ts_plate_map u_map (
    .axis_i(axis_q),
    .drive_i(st_q == ST_REQ || st_q == ST_WAIT || st_q == ST_STAB),
    .sw_o(sw_o), .sel_o(adc_sel_o)
  );

  always_comb begin
    st_n = st_q; ld = 1'b0; ld_val = '0;
    acc_clr = 1'b0; acc_add = 1'b0; fin = 1'b0;
    rpt_set = 1'b0; rpt_rel = 1'b0; tmo = 1'b0;
    case (st_q)
      ST_ARMED: if (touch_det_i) begin
        st_n = ST_DET; ld = 1'b1; ld_val = CNT_W'(DET_CYC - 1);
      end
      ST_DET: if (zero) begin
        if (touch_det_i) begin
          st_n = ST_REQ; rpt_set = set_ok_q;
        end else begin
          st_n = ST_ARMED; rpt_rel = 1'b1;
        end
      end
      ST_REQ: begin
        st_n = ST_WAIT; ld = 1'b1; ld_val = CNT_W'(CONV_CYC - 1);
      end
      ST_WAIT: begin
        if (adc_done_i) begin
          if (smp_q == '0) begin
            st_n = ST_STAB; ld = 1'b1; ld_val = CNT_W'(STAB_CYC - 1);
            acc_clr = 1'b1;
          end else begin
            acc_add = 1'b1;
            st_n = ST_REQ;
            if (smp_q == IDX_W'(AVG_N)) begin
              fin = 1'b1;
              if (axis_q == AX_P) begin
                st_n = ST_DET; ld = 1'b1; ld_val = CNT_W'(DET_CYC - 1);
              end
            end
          end
        end else if (zero) begin
          tmo = 1'b1;
          st_n = ST_DET; ld = 1'b1; ld_val = CNT_W'(DET_CYC - 1);
        end
      end
      ST_STAB: if (zero) st_n = ST_REQ;
      default: st_n = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_ARMED; axis_q <= AX_X; smp_q <= '0; set_ok_q <= 1'b0;
      x_q <= '0; y_q <= '0; p_q <= '0;
      rpt_valid_o <= 1'b0; rpt_touch_o <= 1'b0;
      rpt_x_o <= '0; rpt_y_o <= '0; rpt_p_o <= '0;
    end else begin
      st_q        <= st_n;
      rpt_valid_o <= rpt_set | rpt_rel;
      if (st_q == ST_DET && st_n == ST_REQ) begin
        axis_q <= AX_X; smp_q <= '0;
      end
      if (tmo) smp_q <= '0;
      if (st_q == ST_WAIT && adc_done_i) begin
        smp_q <= fin ? '0 : smp_q + 1'b1;
        if (fin) begin
          case (axis_q)
            AX_X:    begin x_q <= avg; axis_q <= AX_Y; end
            AX_Y:    begin y_q <= avg; axis_q <= AX_P; end
            default: p_q <= avg;
          endcase
        end
      end
      if (fin && axis_q == AX_P)           set_ok_q <= 1'b1;
      else if (rpt_set | rpt_rel | tmo)    set_ok_q <= 1'b0;
      if (rpt_set) begin
        rpt_touch_o <= 1'b1;
        rpt_x_o <= x_q; rpt_y_o <= y_q; rpt_p_o <= p_q;
      end else if (rpt_rel) begin
        rpt_touch_o <= 1'b0;
        rpt_p_o     <= '0;
      end
    end
  end

  assign det_en_o  = (st_q == ST_ARMED) || (st_q == ST_DET);
  assign irq_arm_o = (st_q == ST_ARMED);
  assign adc_req_o = (st_q == ST_REQ);
endmodule

// File: rtl/ts_seq_chk.sv
module ts_seq_chk
  import ts_seq_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              det_en_o,
  input logic              irq_arm_o,
  input logic [4:0]        sw_o,
  input logic [1:0]        adc_sel_o,
  input logic              adc_req_o,
  input logic              rpt_valid_o,
  input logic              rpt_touch_o,
  input logic [DATA_W-1:0] rpt_p_o
);
  // R1
  armed_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_arm_o |-> (det_en_o && sw_o == '0));

  // R2
  det_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_en_o |-> (sw_o == '0));

  // R8
  req_no_det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o |-> !det_en_o);

  // R8
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o |=> !adc_req_o);

  // R3
  x_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_req_o && adc_sel_o == 2'd0) |-> (sw_o == SW_X));

  // R4
  y_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_req_o && adc_sel_o == 2'd1) |-> (sw_o == SW_Y));

  // R5
  p_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_req_o && adc_sel_o == 2'd2) |-> (sw_o == SW_P));

  // R10
  rpt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |=> !rpt_valid_o);

  // R11
  release_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_o && !rpt_touch_o) |-> (rpt_p_o == '0 && irq_arm_o));
endmodule

bind ts_seq ts_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .det_en_o(det_en_o), .irq_arm_o(irq_arm_o),
  .sw_o(sw_o), .adc_sel_o(adc_sel_o), .adc_req_o(adc_req_o),
  .rpt_valid_o(rpt_valid_o), .rpt_touch_o(rpt_touch_o), .rpt_p_o(rpt_p_o)
);

// File: tb/ts_seq_tb.sv
`timescale 1ns/1ps
module ts_seq_tb;
  localparam int DET  = 20;
  localparam int STAB = 12;
  localparam int CONV = 40;
  localparam int LAT  = 3;

  // x base, y base, p base, step between the four kept samples
  localparam logic [17:0] VEC [4][4] = '{
    '{18'h00100, 18'h00200, 18'h00300, 18'd0},
    '{18'h12345, 18'h0ABCD, 18'h00777, 18'd1},
    '{18'h3FFF0, 18'h3FFF8, 18'h20000, 18'd2},
    '{18'h00000, 18'h00005, 18'h1FFFF, 18'd7}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0, touch_det_i = 1'b0, adc_done_i = 1'b0;
  logic [17:0] adc_data_i = '0;
  logic        det_en_o, irq_arm_o, adc_req_o, rpt_valid_o, rpt_touch_o;
  logic [4:0]  sw_o;
  logic [1:0]  adc_sel_o;
  logic [17:0] rpt_x_o, rpt_y_o, rpt_p_o;

  int checks = 0, errors = 0;
  int cyc = 0, req_total = 0, pass_pos = 0, disc_cyc = 0;
  int drop_pos = -1, drop_cyc = -1, pend = 0;
  bit pend_disc = 0;
  logic [17:0] pend_data;
  logic [17:0] bx = '0, by = '0, bp = '0, bd = '0;
  int rpt_cnt = 0, tch_cnt = 0, req_at_rpt = 0;
  logic [17:0] lx, ly, lp;
  logic lt;

  ts_seq #(.DATA_W(18), .AVG_N(4), .DET_CYC(DET), .STAB_CYC(STAB), .CONV_CYC(CONV)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .touch_det_i(touch_det_i), .det_en_o(det_en_o),
    .irq_arm_o(irq_arm_o), .sw_o(sw_o), .adc_sel_o(adc_sel_o), .adc_req_o(adc_req_o),
    .adc_done_i(adc_done_i), .adc_data_i(adc_data_i), .rpt_valid_o(rpt_valid_o),
    .rpt_touch_o(rpt_touch_o), .rpt_x_o(rpt_x_o), .rpt_y_o(rpt_y_o), .rpt_p_o(rpt_p_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_avg(input logic [17:0] b, input logic [17:0] d);
    logic [20:0] s;
    s = (21'(b) << 2) + 21'(d) * 21'd6;
    return s[19:2];
  endfunction

  // ADC responder, request monitor and report monitor
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      if (rpt_valid_o) begin
        rpt_cnt++;
        if (rpt_touch_o) tch_cnt++;
        lx = rpt_x_o; ly = rpt_y_o; lp = rpt_p_o; lt = rpt_touch_o;
        req_at_rpt = req_total;
      end
      if (drop_cyc >= 0 && cyc == drop_cyc + CONV)
        check(det_en_o == 1'b0, "R9", 32'(det_en_o), 32'd0);
      if (drop_cyc >= 0 && cyc == drop_cyc + CONV + 1) begin
        check(det_en_o == 1'b1, "R9", 32'(det_en_o), 32'd1);
        drop_cyc = -1;
      end
      if (det_en_o) pass_pos = 0;
      adc_done_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          adc_done_i = 1'b1;
          adc_data_i = pend_data;
          if (pend_disc) disc_cyc = cyc;
        end
      end
      if (adc_req_o) begin
        int sel_e, idx;
        logic [17:0] b;
        logic [4:0] swe;
        req_total++;
        sel_e = pass_pos / 5;
        idx   = pass_pos % 5;
        check(32'(adc_sel_o) == 32'(sel_e), "R8", 32'(adc_sel_o), 32'(sel_e));
        check(det_en_o == 1'b0, "R8", 32'(det_en_o), 32'd0);
        case (sel_e)
          0: begin swe = 5'b00011; b = bx; check(sw_o == swe, "R3", 32'(sw_o), 32'(swe)); end
          1: begin swe = 5'b01100; b = by; check(sw_o == swe, "R4", 32'(sw_o), 32'(swe)); end
          default: begin swe = 5'b10100; b = bp; check(sw_o == swe, "R5", 32'(sw_o), 32'(swe)); end
        endcase
        if (idx == 1)
          check(cyc - disc_cyc == STAB + 1, "R6", 32'(cyc - disc_cyc), 32'(STAB + 1));
        if (pass_pos == drop_pos) begin
          drop_pos = -1;
          drop_cyc = cyc;
        end else begin
          pend      = LAT;
          pend_disc = (idx == 0);
          pend_data = (idx == 0) ? 18'h3FFFF : b + 18'(idx - 1) * bd;
        end
        pass_pos++;
      end
    end
  end

  task automatic wait_rpt(input int r0);
    while (rpt_cnt == r0) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r0, t0, q0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(det_en_o && irq_arm_o, "R1", {det_en_o, irq_arm_o}, 2'b11);
    check(sw_o == '0 && !adc_req_o && !rpt_valid_o, "R1", {sw_o, adc_req_o, rpt_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check(irq_arm_o && sw_o == '0 && !adc_req_o, "R1", {irq_arm_o, sw_o, adc_req_o}, 6'b100000);

    // R2: short glitch, detector reads no touch after the settle window
    q0 = req_total; r0 = rpt_cnt;
    touch_det_i = 1'b1;
    repeat (3) @(negedge clk_i);
    touch_det_i = 1'b0;
    repeat (DET - 3) @(negedge clk_i);
    check(rpt_valid_o == 1'b0, "R2", 32'(rpt_valid_o), 32'd0);
    @(negedge clk_i);
    check(rpt_valid_o == 1'b1 && rpt_touch_o == 1'b0, "R2", {rpt_valid_o, rpt_touch_o}, 2'b10);
    check(req_total == q0, "R2", 32'(req_total), 32'(q0));
    repeat (3) @(negedge clk_i);

    // table walk: touch, one report, release while the next set is pending
    for (int v = 0; v < 4; v++) begin
      bx = VEC[v][0]; by = VEC[v][1]; bp = VEC[v][2]; bd = VEC[v][3];
      r0 = rpt_cnt; t0 = tch_cnt; q0 = req_total;
      touch_det_i = 1'b1;
      wait_rpt(r0);
      check(lt == 1'b1, "R10", 32'(lt), 32'd1);
      check(req_at_rpt - q0 == 15, "R10", 32'(req_at_rpt - q0), 32'd15);
      check(lx == exp_avg(bx, bd), "R7", lx, exp_avg(bx, bd));
      check(ly == exp_avg(by, bd), "R7", ly, exp_avg(by, bd));
      check(lp == exp_avg(bp, bd), "R7", lp, exp_avg(bp, bd));
      touch_det_i = 1'b0;
      r0 = rpt_cnt;
      wait_rpt(r0);
      check(lt == 1'b0 && lp == '0, "R11", {lt, lp}, 0);
      check(lx == exp_avg(bx, bd), "R11", lx, exp_avg(bx, bd));
      check(tch_cnt - t0 == 1, "R11", 32'(tch_cnt - t0), 32'd1);
      check(req_at_rpt - q0 == 30, "R11", 32'(req_at_rpt - q0), 32'd30);
      check(irq_arm_o == 1'b1, "R11", 32'(irq_arm_o), 32'd1);
      repeat (4) @(negedge clk_i);
    end

    // R9: withhold the Y discard conversion of the first pass
    bx = 18'h01111; by = 18'h02222; bp = 18'h03333; bd = 18'd3;
    drop_pos = 5;
    r0 = rpt_cnt; q0 = req_total;
    touch_det_i = 1'b1;
    wait_rpt(r0);
    check(req_at_rpt - q0 == 21, "R9", 32'(req_at_rpt - q0), 32'd21);
    check(lt == 1'b1 && ly == exp_avg(by, bd), "R9", ly, exp_avg(by, bd));
    r0 = rpt_cnt;
    wait_rpt(r0);
    check(lt == 1'b1 && req_at_rpt - q0 == 36, "R10", 32'(req_at_rpt - q0), 32'd36);
    check(lp == exp_avg(bp, bd), "R5", lp, exp_avg(bp, bd));
    touch_det_i = 1'b0;
    r0 = rpt_cnt;
    wait_rpt(r0);
    check(lt == 1'b0, "R11", 32'(lt), 32'd0);
    repeat (4) @(negedge clk_i);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule